// File: doc/BRIEF.md
# Wireless LAN / Bluetooth Coexistence Arbiter

This block sits on the WLAN side of a shared 2.4 GHz antenna and answers the Bluetooth radio's per-slot medium requests. It brings the Bluetooth request line and, when configured for the three-wire handshake, the Bluetooth slot-priority line through a small synchronizer into the WLAN clock domain. When a new request appears it makes one decision from the WLAN's own activity flags and holds that decision for the whole slot. The decision drives the WLAN-active response line, which is high when the slot is refused.

When Bluetooth wins the slot, the arbiter tells the local transmit path to hold off. If the three-wire handshake is in use and the antenna bypass is enabled, it also steers the antenna to the Bluetooth radio. In the two-wire handshake only the request and the response take part. Everything is released one clock after the synchronized request drops. The block does no packet scheduling and has no radio control beyond the antenna-select output.

Top module: `coex_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `wl_act_o`, `wlan_holdoff_o` and `ant_sw_o` are all 0 from that edge on. Synchronizer state is cleared as well.
- R2: A new request is decided exactly at the third rising edge after `bt_req_i` goes high. The outputs are all 0 before that edge.
- R3: When `three_wire_i`=1 and `bt_pri_i`=1 (high priority) at the decision, Bluetooth is granted whatever `wlan_busy_i` and `wlan_hipri_i` are. A grant means `wl_act_o`=0 and `wlan_holdoff_o`=1.
- R4: When `three_wire_i`=1 and `bt_pri_i`=0 at the decision, the slot is denied if `wlan_busy_i` or `wlan_hipri_i` is 1, and granted otherwise. A denial means `wl_act_o`=1, `wlan_holdoff_o`=0 and `ant_sw_o`=0.
- R5: When `three_wire_i`=0 at the decision, the slot is denied exactly when `wlan_busy_i` is 1. `bt_pri_i` and `wlan_hipri_i` have no effect.
- R6: `ant_sw_o` is 1 for a granted slot only if `three_wire_i`=1 and `ant_bypass_en_i`=1 at the decision. It is 0 otherwise.
- R7: Once decided, all three outputs stay constant for the whole slot. They ignore later changes of `bt_pri_i`, `wlan_busy_i`, `wlan_hipri_i`, `three_wire_i` and `ant_bypass_en_i`.
- R8: After `bt_req_i` falls, all outputs return to 0 at the third rising edge. A following request is decided afresh from the inputs present at its own decision edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | WLAN-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| three_wire_i | input | 1 | 1 selects the handshake with the priority line, 0 the request/response-only handshake |
| ant_bypass_en_i | input | 1 | Policy: allow direct antenna steering to Bluetooth |
| bt_req_i | input | 1 | Asynchronous Bluetooth slot request |
| bt_pri_i | input | 1 | Asynchronous Bluetooth slot priority (1 = high) |
| wlan_busy_i | input | 1 | WLAN transaction in progress |
| wlan_hipri_i | input | 1 | WLAN high-priority traffic flag |
| wl_act_o | output | 1 | 1 = Bluetooth slot refused and blocked |
| ant_sw_o | output | 1 | 1 = antenna steered to Bluetooth |
| wlan_holdoff_o | output | 1 | 1 = WLAN transmit path must hold off |

## Verification
Every result is due at the third rising edge after the request line changes: two synchronizer flops and the slot register. The same holds for release after the request drops. The bench drives inputs on falling edges. Each vector is sampled on the falling edge after the second rising edge, where the outputs must still be idle, and again after the third, where the decision must be present. This pins the latency to exactly that edge rather than "eventually". The directed tests change the WLAN flags, the priority and the mode in the middle of a slot, then sample over several cycles so that any leak of those inputs into the held decision shows up.

// File: rtl/coex_pkg.sv
// Package: shared types for the coexistence arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package coex_pkg;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_t;

    // Outcome of one slot decision; each field drives one output flop.
    typedef struct packed {
        logic deny;   // refuse the Bluetooth slot
        logic grant;  // Bluetooth owns the medium
        logic ant;    // steer antenna to Bluetooth
    } verdict_t;

endpackage

// File: rtl/coex_sync.sv
// Module: coex_sync
// Multi-stage synchronizer bank that brings asynchronous single-bit lines into
// the clock domain. Assumes each bit is independent (no bus coherence needed).
module coex_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: shift each bit one stage deeper, clearing on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else if (s == 0) begin
                chain_q[s] <= async_i;
            end else begin
                chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/coex_policy.sv
// Module: coex_policy
// Combinational slot policy: turns the synchronized priority, the handshake
// mode and the WLAN activity flags into a verdict. Assumes it is only looked at
// on the cycle a new request is seen; the slot FSM does the holding.
module coex_policy
    import coex_pkg::*;
(
    input  logic     three_wire_i,
    input  logic     pri_i,
    input  logic     wlan_busy_i,
    input  logic     wlan_hipri_i,
    input  logic     ant_en_i,
    output verdict_t verdict_o
);
    logic refuse;

    // Purpose: pick the refusal rule for the active handshake.
    always_comb begin
        if (three_wire_i) begin
            refuse = !pri_i && (wlan_busy_i || wlan_hipri_i);
        end else begin
            refuse = wlan_busy_i;
        end
    end

    // Purpose: pack the verdict; the antenna follows a grant only with the
    // priority-line handshake and the bypass enabled.
    always_comb begin
        verdict_o.deny  = refuse;
        verdict_o.grant = !refuse;
        verdict_o.ant   = !refuse && three_wire_i && ant_en_i;
    end

endmodule

// File: rtl/coex_slot_fsm.sv
// Module: coex_slot_fsm
// Holds one verdict per Bluetooth slot. Latches the verdict on the first cycle
// the synchronized request is seen in idle and clears everything on the cycle
// after the synchronized request drops. Assumes req_s_i is already synchronous.
module coex_slot_fsm
    import coex_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_s_i,
    input  logic     pri_s_i,
    input  logic     three_wire_i,
    input  logic     wlan_busy_i,
    input  verdict_t verdict_i,
    output logic     wl_act_o,
    output logic     holdoff_o,
    output logic     ant_o
);
    slot_state_t state_q;
    logic        deny_q;
    logic        grant_q;
    logic        ant_q;

    // Purpose: slot state and per-slot verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            deny_q  <= 1'b0;
            grant_q <= 1'b0;
            ant_q   <= 1'b0;
        end else begin
            case (state_q)
                SLOT_IDLE: if (req_s_i) begin
                    state_q <= SLOT_HELD;
                    deny_q  <= verdict_i.deny;
                    grant_q <= verdict_i.grant;
                    ant_q   <= verdict_i.ant;
                end
                SLOT_HELD: if (!req_s_i) begin
                    state_q <= SLOT_IDLE;
                    deny_q  <= 1'b0;
                    grant_q <= 1'b0;
                    ant_q   <= 1'b0;
                end
                default: state_q <= SLOT_IDLE;
            endcase
        end
    end

    assign wl_act_o  = deny_q;
    assign holdoff_o = grant_q;
    assign ant_o     = ant_q;

    // R7: a decided slot keeps its outputs while the request stays up.
    p_slot_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && req_s_i) |=> ($stable(wl_act_o) && $stable(holdoff_o) && $stable(ant_o)));

    // R8: a dropped request clears every output on the next edge.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && !req_s_i) |=> (!wl_act_o && !holdoff_o && !ant_o));

    // R3: high priority on the priority-line handshake is always granted.
    p_hipri_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_IDLE && req_s_i && three_wire_i && pri_s_i) |=> (holdoff_o && !wl_act_o));

    // R5: with the two-wire handshake a busy WLAN refuses the slot.
    p_twowire_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_IDLE && req_s_i && !three_wire_i && wlan_busy_i) |=> (wl_act_o && !holdoff_o));

    // R2: no output while idle and no request is pending.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_IDLE && !req_s_i) |=> (!wl_act_o && !holdoff_o && !ant_o));

endmodule

// File: rtl/coex_arbiter.sv
// Module: coex_arbiter (top)
// WLAN-side coexistence arbiter for the two-wire and three-wire Bluetooth
// handshakes. Synchronizes the Bluetooth lines, applies the slot policy and
// holds the verdict per slot. Assumes WLAN flags are in the clk domain.
module coex_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic three_wire_i,
    input  logic ant_bypass_en_i,
    input  logic bt_req_i,
    input  logic bt_pri_i,
    input  logic wlan_busy_i,
    input  logic wlan_hipri_i,
    output logic wl_act_o,
    output logic ant_sw_o,
    output logic wlan_holdoff_o
);
    import coex_pkg::*;

    localparam int BT_LINES = 2;
    localparam int IDX_REQ  = 0;
    localparam int IDX_PRI  = 1;

    logic [BT_LINES-1:0] bt_sync;
    verdict_t            verdict;

    coex_sync #(
        .WIDTH  (BT_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bt_pri_i, bt_req_i}),
        .sync_o  (bt_sync)
    );

    coex_policy u_policy (
        .three_wire_i (three_wire_i),
        .pri_i        (bt_sync[IDX_PRI]),
        .wlan_busy_i  (wlan_busy_i),
        .wlan_hipri_i (wlan_hipri_i),
        .ant_en_i     (ant_bypass_en_i),
        .verdict_o    (verdict)
    );

    coex_slot_fsm u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s_i      (bt_sync[IDX_REQ]),
        .pri_s_i      (bt_sync[IDX_PRI]),
        .three_wire_i (three_wire_i),
        .wlan_busy_i  (wlan_busy_i),
        .verdict_i    (verdict),
        .wl_act_o     (wl_act_o),
        .holdoff_o    (wlan_holdoff_o),
        .ant_o        (ant_sw_o)
    );

    // R4: refusal and hold-off are never raised together.
    p_deny_grant_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wl_act_o && wlan_holdoff_o));

    // R6: the antenna is only steered for a granted slot.
    p_ant_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ant_sw_o |-> wlan_holdoff_o);

    // R1: reset clears the outputs on the following edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!wl_act_o && !wlan_holdoff_o && !ant_sw_o));

endmodule

// File: tb/tb_coex_arbiter.sv
// Bench: table of mode/priority/WLAN-flag vectors, then directed tests.
module tb_coex_arbiter;

    logic clk = 1'b0;
    logic rst_n;
    logic three_wire, ant_en, bt_req, bt_pri, busy, hipri;
    logic wl_act, ant_sw, holdoff;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    coex_arbiter dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .three_wire_i    (three_wire),
        .ant_bypass_en_i (ant_en),
        .bt_req_i        (bt_req),
        .bt_pri_i        (bt_pri),
        .wlan_busy_i     (busy),
        .wlan_hipri_i    (hipri),
        .wl_act_o        (wl_act),
        .ant_sw_o        (ant_sw),
        .wlan_holdoff_o  (holdoff)
    );

    // Vector: {three_wire, pri, busy, hipri, ant_en, exp_act, exp_hold, exp_ant}
    localparam int NVEC = 10;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_1_1_1_1_011,  // R3 high priority beats busy + hipri
        8'b1_1_0_0_0_010,  // R3/R6 granted, bypass off
        8'b1_0_0_0_1_011,  // R4 normal priority, WLAN idle
        8'b1_0_1_0_1_100,  // R4 denied: busy
        8'b1_0_0_1_1_100,  // R4 denied: hipri
        8'b0_1_1_0_1_100,  // R5 busy denies, priority ignored
        8'b0_0_0_1_1_010,  // R5 hipri ignored, R6 no antenna in two-wire
        8'b0_0_0_0_0_010,  // R5 idle granted
        8'b0_1_0_1_1_010,  // R5 priority and hipri ignored
        8'b1_1_0_1_0_010   // R3 hipri flag ignored for high priority
    };

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        checks++;
        if ({wl_act, holdoff, ant_sw} !== exp) begin
            errors++;
            $display("FAIL %s act/hold/ant actual=%b expected=%b", tag,
                     {wl_act, holdoff, ant_sw}, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; three_wire = 0; ant_en = 0; bt_req = 0; bt_pri = 0;
        busy = 0; hipri = 0;
        @(negedge clk);
        tick(3);
        chk("R1 reset state", 3'b000);
        rst_n = 1;
        tick(2);
        chk("R2 idle without request", 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            {three_wire, bt_pri, busy, hipri, ant_en} = VEC[i][7:3];
            bt_req = 1;
            tick(2);
            chk($sformatf("R2 vector %0d not before third edge", i), 3'b000);
            tick(1);
            chk($sformatf("vector %0d decision (R3/R4/R5/R6)", i), VEC[i][2:0]);
            bt_req = 0;
            tick(3);
            chk($sformatf("R8 vector %0d release", i), 3'b000);
            tick(1);
        end

        // R7: decision holds while every policy input flips mid-slot.
        three_wire = 1; bt_pri = 0; busy = 0; hipri = 0; ant_en = 1;
        bt_req = 1;
        tick(3);
        chk("R7 initial grant", 3'b011);
        busy = 1; hipri = 1; bt_pri = 1; three_wire = 0; ant_en = 0;
        tick(1);
        chk("R7 held after input change", 3'b011);
        tick(4);
        chk("R7 still held", 3'b011);

        // R8: release timing exact; then a fresh slot is re-decided.
        bt_req = 0;
        tick(2);
        chk("R8 held until third edge", 3'b011);
        tick(1);
        chk("R8 cleared at third edge", 3'b000);
        three_wire = 1; bt_pri = 0;
        bt_req = 1;
        tick(3);
        chk("R8 next slot re-decided as deny", 3'b100);
        bt_req = 0;
        tick(4);

        // R1: reset in the middle of a granted slot.
        busy = 0; hipri = 0; ant_en = 1;
        bt_req = 1;
        tick(3);
        chk("R1 pre-reset grant", 3'b011);
        rst_n = 0;
        tick(1);
        chk("R1 reset mid-slot clears", 3'b000);
        rst_n = 1;
        tick(3);
        chk("R1 request re-decided after reset", 3'b011);
        bt_req = 0;
        tick(3);
        chk("R8 final release", 3'b000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule